// File: doc/BRIEF.md
# Set-Associative Hit Predictor (Tag Directory)

This block is a directory of tags with no line data behind it. A processor timing model, or a performance monitor next to a real memory path, sends it one request per cycle: an address, a read/write flag and a valid strobe. One cycle later the block reports whether that access would have hit in a set-associative cache of the configured geometry. The geometry is given in log2 form: total bytes, ways and line bytes. With the defaults there are 4096 bytes, 4 ways and 32-byte lines, so the directory has 32 sets.

Each set has its own round-robin victim pointer. A new line is placed in the directory only when a read misses. A write that misses leaves every piece of state as it was. A one-entry register holds the line address of the most recent resident line that was touched. A request to that same line is reported as a hit without consulting the tag array. Reset empties the directory to all-zero tags and returns every victim pointer to way 0. It also loads the shortcut register with a value that no request can match.

Top module: `tagdir_hit_predictor`

## Requirements
- R1: `resp_valid_o` is high in the cycle after each cycle in which `req_valid_i` was sampled high out of reset, and low otherwise. `hit_o` is high only together with `resp_valid_o`.
- R2: A request whose line address (`req_addr_i` above bit LINE_LOG2-1) equals that of the previous read request is reported as a hit, provided the two requests came in consecutive cycles.
- R3: The set is `req_addr_i[LINE_LOG2+SET_LOG2-1:LINE_LOG2]` and the tag is all bits above it. A request hits when its tag is held in any way of its set.
- R4: A read miss writes the tag into the way named by the set's victim pointer, and that pointer then advances by one modulo the number of ways. After WAYS+1 distinct tags have been read into one set with no hits in between, the first tag misses again.
- R5: A write miss allocates nothing. A read of the same line that follows it still misses.
- R6: A write to a resident line is reported as a hit and allocates nothing.
- R7: After reset every tag is zero, so any address whose tag field is zero hits. The shortcut register matches no request, so the line at address 0xFFFFFFE0 misses.
- R8: When reset is low in the same cycle as a request, that request gets no response (`resp_valid_o` and `hit_o` are low the next cycle) and the directory state is cleared.
- R9: Sets are independent. The same tag in a different set misses until it is read into that set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the request |
| resp_valid_o | output | 1 | Result of the previous cycle's request is present |
| hit_o | output | 1 | That request would have hit |

## Verification
Two events can occur in the same cycle. One is the update made by a request: an allocation into a victim way, or a load of the shortcut register. The other is the lookup of the very next request, which must already see that update. The bench provokes this by sending requests back to back every cycle: repeated lines, eviction chains longer than the associativity, and writes followed at once by reads of the same line. Each result is judged against a reference model that applies every access in order. Reset arriving together with a request is driven directly. It is judged by a missing response and by a formerly resident line that now misses.

// File: rtl/tdir_pkg.sv
// Package: shared types of the tag directory.
// Assumes: nothing beyond IEEE 1800-2017.
package tdir_pkg;
    // Direction of a request as carried on req_write_i.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } tdir_dir_e;
endpackage

// File: rtl/tdir_tag_store.sv
// Module: tag array plus one round-robin victim pointer per set.
// Reads all ways of one set combinationally. It writes one tag per cycle into the
// victim way of the chosen set and advances that set's pointer.
// Assumes: the caller asserts wr_en only for a read miss.
module tdir_tag_store #(
    parameter int SET_LOG2  = 5,
    parameter int WAYS_LOG2 = 2,
    parameter int TAG_W     = 22
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_LOG2-1:0]            rd_set,
    output logic [(1<<WAYS_LOG2)-1:0][TAG_W-1:0] rd_tags,
    input  logic                           wr_en,
    input  logic [SET_LOG2-1:0]            wr_set,
    input  logic [TAG_W-1:0]               wr_tag
);
    localparam int SETS  = 1 << SET_LOG2;
    localparam int WAYS  = 1 << WAYS_LOG2;
    localparam int PTR_W = (WAYS_LOG2 > 0) ? WAYS_LOG2 : 1;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PTR_W-1:0] rr_q  [SETS];

    // Purpose: clear on reset, otherwise place a tag in the victim way and advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            tag_q[wr_set][rr_q[wr_set]] <= wr_tag;
            if (rr_q[wr_set] == PTR_W'(WAYS - 1)) begin
                rr_q[wr_set] <= '0;
            end else begin
                rr_q[wr_set] <= rr_q[wr_set] + PTR_W'(1);
            end
        end
    end

    // Purpose: present every way of the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tags[w] = tag_q[rd_set][w];
        end
    end
endmodule

// File: rtl/tdir_way_match.sv
// Module: compares the request tag against every way in parallel.
// Assumes: the tags belong to the set the request indexes.
module tdir_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]           req_tag,
    output logic [WAYS-1:0]            way_hit,
    output logic                       any_hit
);
    // One comparator for each way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = (way_tags[w] == req_tag);
    end

    // Purpose: fold the per-way results into one flag.
    assign any_hit = |way_hit;
endmodule

// File: rtl/tdir_last_block.sv
// Module: one-entry register holding the most recent resident line address.
// An extra top bit stays set after reset, so no request can match until the first update.
// Assumes: upd_en is raised only for a line that is, or now becomes, resident.
module tdir_last_block #(
    parameter int BLK_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] req_blk,
    output logic             match,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] upd_blk
);
    logic [BLK_W:0] last_q;

    // Purpose: load the poisoned value on reset, otherwise the newly touched line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '1;
        end else if (upd_en) begin
            last_q <= {1'b0, upd_blk};
        end
    end

    // Purpose: compare the request's line with the stored one.
    assign match = (last_q == {1'b0, req_blk});
endmodule

// File: rtl/tagdir_hit_predictor.sv
// Module: top of the tag-only hit predictor.
// Decides hit or miss for one request per cycle and registers the result, so it
// appears one cycle later. The next request already sees the state this request updates.
// Assumes: SIZE_LOG2 > WAYS_LOG2 + LINE_LOG2 (at least two sets).
module tagdir_hit_predictor #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_LOG2 = 12,
    parameter int WAYS_LOG2 = 2,
    parameter int LINE_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              resp_valid_o,
    output logic              hit_o
);
    import tdir_pkg::*;

    localparam int SET_LOG2 = SIZE_LOG2 - WAYS_LOG2 - LINE_LOG2;
    localparam int WAYS     = 1 << WAYS_LOG2;
    localparam int TAG_W    = ADDR_W - LINE_LOG2 - SET_LOG2;
    localparam int BLK_W    = ADDR_W - LINE_LOG2;

    tdir_dir_e                   req_dir;
    logic [BLK_W-1:0]            req_blk;
    logic [SET_LOG2-1:0]         req_set;
    logic [TAG_W-1:0]            req_tag;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [WAYS-1:0]             way_hit;
    logic                        tag_hit;
    logic                        short_hit;
    logic                        lookup_hit;
    logic                        alloc_en;
    logic                        last_upd;

    // Purpose: split the address into line, set and tag fields.
    assign req_dir = tdir_dir_e'(req_write_i);
    assign req_blk = req_addr_i[ADDR_W-1:LINE_LOG2];
    assign req_set = req_addr_i[LINE_LOG2+SET_LOG2-1:LINE_LOG2];
    assign req_tag = req_addr_i[ADDR_W-1:LINE_LOG2+SET_LOG2];

    tdir_tag_store #(
        .SET_LOG2 (SET_LOG2),
        .WAYS_LOG2(WAYS_LOG2),
        .TAG_W    (TAG_W)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (req_set),
        .rd_tags(set_tags),
        .wr_en  (alloc_en),
        .wr_set (req_set),
        .wr_tag (req_tag)
    );

    tdir_way_match #(
        .WAYS (WAYS),
        .TAG_W(TAG_W)
    ) match_i (
        .way_tags(set_tags),
        .req_tag (req_tag),
        .way_hit (way_hit),
        .any_hit (tag_hit)
    );

    tdir_last_block #(
        .BLK_W(BLK_W)
    ) last_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_blk(req_blk),
        .match  (short_hit),
        .upd_en (last_upd),
        .upd_blk(req_blk)
    );

    // Purpose: the shortcut hit wins; otherwise the tag lookup decides.
    assign lookup_hit = short_hit | tag_hit;

    // Purpose: allocate only when a read misses both the shortcut and the tags.
    assign alloc_en = req_valid_i && (req_dir == DIR_READ) && !lookup_hit;

    // Purpose: refresh the shortcut after a tag hit or a read miss, never after a write miss.
    assign last_upd = req_valid_i && !short_hit && (tag_hit || (req_dir == DIR_READ));

    // Purpose: register the result; reset drops any request of the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            hit_o        <= 1'b0;
        end else begin
            resp_valid_o <= req_valid_i;
            hit_o        <= req_valid_i && lookup_hit;
        end
    end
endmodule

// File: rtl/tagdir_hit_predictor_chk.sv
// Module: property checker for the hit predictor, attached by bind.
// Assumes: reset is driven low from time zero.
module tagdir_hit_predictor_chk #(
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              resp_valid_o,
    input logic              hit_o
);
    // R1: every sampled request yields a response in the next cycle.
    assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> resp_valid_o);

    // R1: no request means no response.
    assert_no_spurious_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !resp_valid_o);

    // R1: a hit is only ever reported alongside a response.
    assert_hit_needs_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> resp_valid_o);

    // R2: a line read in the previous cycle is resident for the next request.
    assert_repeat_line_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && $past(rst_n) && $past(req_valid_i) && !$past(req_write_i)
         && (req_addr_i[ADDR_W-1:LINE_LOG2] == $past(req_addr_i[ADDR_W-1:LINE_LOG2])))
        |=> hit_o);

    // R5: a read right after a write miss to the same line still misses.
    assert_write_miss_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && $past(rst_n) && $past(req_valid_i) && $past(req_write_i)
         && resp_valid_o && !hit_o
         && (req_addr_i[ADDR_W-1:LINE_LOG2] == $past(req_addr_i[ADDR_W-1:LINE_LOG2])))
        |=> !hit_o);

    // R8: reset silences the response to any request of the same cycle.
    assert_reset_drops_req_R8: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid_o && !hit_o));
endmodule

bind tagdir_hit_predictor tagdir_hit_predictor_chk #(
    .ADDR_W   (ADDR_W),
    .LINE_LOG2(LINE_LOG2)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .resp_valid_o(resp_valid_o),
    .hit_o       (hit_o)
);

// File: tb/tagdir_hit_predictor_tb_top.sv
`timescale 1ns/1ps
// Bench: table of directed vectors, directed reset cases, then random streams
// checked against a reference model. Default geometry: 32 sets, 4 ways, 32-byte lines.
module tagdir_hit_predictor_tb_top;
    localparam int NSETS   = 32;
    localparam int NWAYS   = 4;
    localparam int NVEC    = 16;
    localparam int NRAND   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        resp_valid_o;
    logic        hit_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [21:0] m_tag [NSETS][NWAYS];
    int          m_rr  [NSETS];
    logic [27:0] m_last;

    always #2.5 clk = ~clk;

    tagdir_hit_predictor dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .resp_valid_o(resp_valid_o),
        .hit_o       (hit_o)
    );

    // Each entry: {write, address, expected hit}; geometry: tag = addr[31:10], set = addr[9:5].
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 32'h0000_0460, 1'b0}, // R4 tag1 set3 read miss -> way0
        {1'b0, 32'h0000_0464, 1'b1}, // R2 same line shortcut
        {1'b1, 32'h0000_0860, 1'b0}, // R5 write miss tag2
        {1'b0, 32'h0000_0860, 1'b0}, // R5 still absent -> way1
        {1'b0, 32'h0000_0460, 1'b1}, // R3 tag1 via lookup
        {1'b0, 32'h0000_0C60, 1'b0}, // R4 tag3 -> way2
        {1'b0, 32'h0000_1060, 1'b0}, // R4 tag4 -> way3
        {1'b0, 32'h0000_1460, 1'b0}, // R4 tag5 evicts tag1
        {1'b0, 32'h0000_0460, 1'b0}, // R4 tag1 gone, evicts tag2
        {1'b0, 32'h0000_0C60, 1'b1}, // R3 tag3 resident
        {1'b0, 32'h0000_0860, 1'b0}, // R4 tag2 gone, evicts tag3
        {1'b0, 32'h0000_1060, 1'b1}, // R3 tag4 resident
        {1'b0, 32'h0000_1480, 1'b0}, // R9 tag5 in set4 misses
        {1'b0, 32'h0000_1460, 1'b1}, // R9 tag5 in set3 still hits
        {1'b1, 32'h0000_1480, 1'b1}, // R6 write hit
        {1'b1, 32'h0000_00E0, 1'b1}  // R7 zero tag hits after reset
    };

    function automatic string row_req(input int i);
        case (i)
            1:            return "R2";
            2, 3:         return "R5";
            4, 9, 11:     return "R3";
            12, 13:       return "R9";
            14:           return "R6";
            15:           return "R7";
            default:      return "R4";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NSETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < NWAYS; w++) m_tag[s][w] = '0;
        end
        m_last = '1;
        m_last[27] = 1'b1;
    endtask

    // Reference: returns the expected hit and updates the model.
    function automatic logic model_access(input logic [31:0] a, input logic wr);
        logic [27:0] blk;
        int          st;
        blk = {1'b0, a[31:5]};
        st  = int'(a[9:5]);
        if (blk == m_last) return 1'b1;
        for (int w = 0; w < NWAYS; w++) begin
            if (m_tag[st][w] == a[31:10]) begin
                m_last = blk;
                return 1'b1;
            end
        end
        if (!wr) begin
            m_tag[st][m_rr[st]] = a[31:10];
            m_rr[st] = (m_rr[st] + 1) % NWAYS;
            m_last = blk;
        end
        return 1'b0;
    endfunction

    // Drive one request at the falling edge; sample its result 1 ns after the next rising edge.
    task automatic issue(input logic [31:0] a, input logic wr);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_addr_i  = a;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid_i = 1'b0;
        req_write_i = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic exp;
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        // R7 reset state of the outputs
        check("R7", "reset resp_valid", resp_valid_o, 1'b0);
        check("R7", "reset hit", hit_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk, back to back.
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][32:1], VEC[i][33]);
            exp = model_access(VEC[i][32:1], VEC[i][33]);
            check("R1", $sformatf("row %0d resp_valid", i), resp_valid_o, 1'b1);
            check(row_req(i), $sformatf("row %0d hit", i), hit_o, VEC[i][0]);
        end
        idle();
        @(posedge clk);
        #1;
        check("R1", "idle resp_valid", resp_valid_o, 1'b0);

        // R8: reset together with a request.
        @(negedge clk);
        rst_n       = 1'b0;
        req_valid_i = 1'b1;
        req_write_i = 1'b0;
        req_addr_i  = 32'h0000_1460;
        @(posedge clk);
        #1;
        check("R8", "resp_valid under reset", resp_valid_o, 1'b0);
        check("R8", "hit under reset", hit_o, 1'b0);
        @(negedge clk);
        req_valid_i = 1'b0;
        rst_n       = 1'b1;
        model_reset();
        issue(32'h0000_1460, 1'b0);
        check("R8", "resident line cleared by reset", hit_o, 1'b0);
        exp = model_access(32'h0000_1460, 1'b0);
        idle();
        // R7: shortcut poisoned after reset; all-ones line misses.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        issue(32'hFFFF_FFE0, 1'b0);
        check("R7", "all-ones line after reset", hit_o, 1'b0);
        exp = model_access(32'hFFFF_FFE0, 1'b0);
        issue(32'hFFFF_FFFC, 1'b1);
        check("R2", "all-ones line second access", hit_o, 1'b1);
        exp = model_access(32'hFFFF_FFFC, 1'b1);

        // Random streams: tags 1..6, sets 0..3, a quarter writes (R4, R5, R9 aliasing).
        for (int n = 0; n < NRAND; n++) begin
            logic [31:0] a;
            logic        wr;
            a  = {19'd0, 3'(1 + ($urandom % 6)), 3'd0, 2'($urandom % 4), 5'($urandom % 32)};
            wr = (($urandom % 4) == 0);
            issue(a, wr);
            exp = model_access(a, wr);
            check("R4", $sformatf("random %0d addr %h wr %b", n, a, wr), hit_o, exp);
        end
        idle();
        @(posedge clk);
        #1;
        check("R1", "final idle resp_valid", resp_valid_o, 1'b0);
        summary();
    end
endmodule